// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a CAN frame that has just finished arriving should be written into the receive buffer. When the frame completes, the receiver raises a one-cycle strobe. In that cycle it presents the frame format, the identifier, the RTR bit, the data length code and the first two data bytes. The filter compares these against a 32-bit acceptance code. A 32-bit acceptance mask marks which bit positions are don't care. The result is a registered accept pulse one clock later.

A mode input selects between two modes. In single mode, one 32-bit filter covers the whole compared field. In dual mode, two independent 16-bit filters each look at the leading part of the frame, and either one may accept. The compared field depends on the frame format:
- A standard frame offers its 11-bit identifier, its RTR bit and its first two data bytes.
- An extended frame offers its 29-bit identifier and its RTR bit.

A standard frame's data bytes that were never sent count as passing. This happens when the RTR bit is set or when the length code is short.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `accept_o` is 0.
- R2: A compared bit passes when its mask bit is 1 or when the received bit equals its code bit. A filter matches only when every compared bit passes. An all-ones mask therefore accepts every frame.
- R3: In single mode with a standard frame, the match uses these code bits:
  - code[31:21] holds identifier bits 10..0, MSB first.
  - code[20] holds RTR.
  - code[15:8] holds data byte 0.
  - code[7:0] holds data byte 1.
  - code and mask bits [19:16] never affect the result.
- R4: In standard frames, a data byte that was not received always passes:
  - Both bytes are absent when RTR is 1 or the length code is 0.
  - Byte 1 is absent when the length code is 1.
  - Any length code of 2 or more, including values above 8, makes both bytes present.
- R5: In single mode with an extended frame, the match uses these code bits:
  - code[31:3] holds identifier bits 28..0, MSB first.
  - code[2] holds RTR.
  - code and mask bits [1:0] never affect the result.
- R6: In dual mode, the frame is accepted when filter A matches or filter B matches:
  - Filter A uses code/mask [31:16].
  - Filter B uses code/mask [15:0].
  - Each filter compares against the frame's leading 16 bits:
    - For a standard frame, these are identifier 10..0, then RTR, then 4 don't-care bits.
    - For an extended frame, these are identifier bits 28..13.
- R7: `accept_o` is 1 for exactly the one cycle after a cycle with `frame_valid_i` high whose frame matches, and 0 in every other cycle. All frame and filter inputs are sampled in the strobe cycle.
- R8: `single_mode_i` = 1 selects single mode and 0 selects dual mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid_i | input | 1 | One-cycle end-of-frame strobe |
| ext_frame_i | input | 1 | 1 = extended (29-bit) identifier, 0 = standard |
| id_i | input | 29 | Identifier; standard frames use bits 10..0 |
| rtr_i | input | 1 | Remote request bit |
| dlc_i | input | 4 | Data length code as received |
| data0_i | input | 8 | First data byte |
| data1_i | input | 8 | Second data byte |
| single_mode_i | input | 1 | Filter mode select |
| acc_code_i | input | 32 | Acceptance code, byte 0 in [31:24] |
| acc_mask_i | input | 32 | Acceptance mask, 1 = don't care |
| accept_o | output | 1 | Registered accept pulse |

## Verification
Directed frames cover the following cases:
- An exact standard match, followed by single-bit flips in the identifier and in each data byte. These separate the identifier path from the data paths.
- RTR set and length codes of 0, 1 and 12 paired with deliberately wrong data codes. These show that only missing bytes are excused.
- Flips in the unused code bits of both formats. These must not change the result.
- Dual-mode frames that match only filter A, only filter B, or neither. These tell the OR of two halves apart from a single 32-bit compare.

Constrained random frames then derive the code from the frame word with a few random bit flips and use sparse random masks. This keeps accepts and rejects both frequent across both formats and both modes.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int BYTE_W     = 8;
  localparam int NBYTES     = 4;
  localparam int WORD_W     = NBYTES * BYTE_W;
  localparam int HALF_W     = WORD_W / 2;
  localparam int EXT_ID_W   = 29;
  localparam int STD_ID_W   = 11;
  localparam int DLC_W      = 4;
  localparam int STD_GAP_W  = WORD_W - STD_ID_W - 1 - 2 * BYTE_W;
  localparam int EXT_GAP_W  = WORD_W - EXT_ID_W - 1;

  typedef struct packed {
    logic [WORD_W-1:0] bits;
    logic [WORD_W-1:0] care;
  } cmp_word_t;

  // bit 1: byte 0 received, bit 0: byte 1 received
  function automatic logic [1:0] data_present(input logic rtr, input logic [DLC_W-1:0] dlc);
    logic [1:0] p;
    p[1] = !rtr && (dlc != '0);
    p[0] = !rtr && (dlc >= DLC_W'(2));
    return p;
  endfunction

  function automatic logic field_match(input logic [WORD_W-1:0] code,
                                       input logic [WORD_W-1:0] mask,
                                       input logic [WORD_W-1:0] rx,
                                       input logic [WORD_W-1:0] care);
    return &(mask | ~(code ^ rx) | ~care);
  endfunction
endpackage

// File: rtl/can_filt_fieldmap.sv
module can_filt_fieldmap
  import can_filt_pkg::*;
(
  input  logic                ext_frame_i,
  input  logic [EXT_ID_W-1:0] id_i,
  input  logic                rtr_i,
  input  logic [DLC_W-1:0]    dlc_i,
  input  logic [BYTE_W-1:0]   data0_i,
  input  logic [BYTE_W-1:0]   data1_i,
  output cmp_word_t           word_o
);
  logic [1:0]        present_w;
  logic [WORD_W-1:0] std_bits_w, std_care_w, ext_bits_w, ext_care_w;

  assign present_w  = data_present(rtr_i, dlc_i);
  assign std_bits_w = {id_i[STD_ID_W-1:0], rtr_i, {STD_GAP_W{1'b0}}, data0_i, data1_i};
  assign std_care_w = {{(STD_ID_W+1){1'b1}}, {STD_GAP_W{1'b0}},
                       {BYTE_W{present_w[1]}}, {BYTE_W{present_w[0]}}};
  assign ext_bits_w = {id_i, rtr_i, {EXT_GAP_W{1'b0}}};
  assign ext_care_w = {{(EXT_ID_W+1){1'b1}}, {EXT_GAP_W{1'b0}}};

  always_comb begin
    if (ext_frame_i) begin
      word_o.bits = ext_bits_w;
      word_o.care = ext_care_w;
    end else begin
      word_o.bits = std_bits_w;
      word_o.care = std_care_w;
    end
  end

  // R4: absent data bytes are never compared
  always_comb begin
    if (!ext_frame_i && (rtr_i || dlc_i == '0))
      p_absent_data_r4: assert (word_o.care[2*BYTE_W-1:0] == '0);
  end

  // R3: unused gap bits of a standard frame are never compared
  always_comb begin
    if (!ext_frame_i)
      p_std_gap_r3: assert (word_o.care[2*BYTE_W+STD_GAP_W-1:2*BYTE_W] == '0);
  end
endmodule

// File: rtl/can_filt_lane.sv
module can_filt_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] care_i,
  output logic         hit_o
);
  logic [W-1:0] pass_w;

  assign pass_w = mask_i | ~(code_i ^ rx_i) | ~care_i;
  assign hit_o  = &pass_w;

  // R2: a fully masked lane must match whatever arrives
  always_comb begin
    if (&mask_i)
      p_all_dontcare_r2: assert (hit_o);
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid_i,
  input  logic                ext_frame_i,
  input  logic [EXT_ID_W-1:0] id_i,
  input  logic                rtr_i,
  input  logic [DLC_W-1:0]    dlc_i,
  input  logic [BYTE_W-1:0]   data0_i,
  input  logic [BYTE_W-1:0]   data1_i,
  input  logic                single_mode_i,
  input  logic [WORD_W-1:0]   acc_code_i,
  input  logic [WORD_W-1:0]   acc_mask_i,
  output logic                accept_o
);
  localparam int NLANES = 2;

  cmp_word_t         word_w;
  logic              single_hit_w;
  logic [NLANES-1:0] dual_hit_w;
  logic              dual_any_w;
  logic              hit_now_w;

  can_filt_fieldmap u_map (
    .ext_frame_i (ext_frame_i),
    .id_i        (id_i),
    .rtr_i       (rtr_i),
    .dlc_i       (dlc_i),
    .data0_i     (data0_i),
    .data1_i     (data1_i),
    .word_o      (word_w)
  );

  can_filt_lane #(.W(WORD_W)) u_single (
    .code_i (acc_code_i),
    .mask_i (acc_mask_i),
    .rx_i   (word_w.bits),
    .care_i (word_w.care),
    .hit_o  (single_hit_w)
  );

  // lane 0 = filter A on the upper half of code/mask, lane 1 = filter B on the lower half
  for (genvar g = 0; g < NLANES; g++) begin : g_dual
    can_filt_lane #(.W(HALF_W)) u_half (
      .code_i (acc_code_i[WORD_W-1-g*HALF_W -: HALF_W]),
      .mask_i (acc_mask_i[WORD_W-1-g*HALF_W -: HALF_W]),
      .rx_i   (word_w.bits[WORD_W-1 -: HALF_W]),
      .care_i (word_w.care[WORD_W-1 -: HALF_W]),
      .hit_o  (dual_hit_w[g])
    );
  end

  assign dual_any_w = |dual_hit_w;
  assign hit_now_w  = single_mode_i ? single_hit_w : dual_any_w;

  always_ff @(posedge clk) begin
    if (!rst_n) accept_o <= 1'b0;
    else        accept_o <= frame_valid_i && hit_now_w;
  end

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid_i |=> !accept_o);

  p_open_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_i && (&acc_mask_i)) |=> accept_o);

  p_single_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_i && single_mode_i && !single_hit_w) |=> !accept_o);

  p_dual_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_i && !single_mode_i && (dual_hit_w == '0)) |=> !accept_o);
endmodule

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid_i = 1'b0;
  logic        ext_frame_i = 1'b0;
  logic [28:0] id_i = '0;
  logic        rtr_i = 1'b0;
  logic [3:0]  dlc_i = '0;
  logic [7:0]  data0_i = '0;
  logic [7:0]  data1_i = '0;
  logic        single_mode_i = 1'b1;
  logic [31:0] acc_code_i = '0;
  logic [31:0] acc_mask_i = '0;
  logic        accept_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  can_accept_filter dut (.*);

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // independent bit-by-bit model of the requirements
  function automatic bit ref_accept(bit ext, bit [28:0] id, bit rtr, bit [3:0] dlc,
                                    bit [7:0] d0, bit [7:0] d1, bit single,
                                    bit [31:0] code, bit [31:0] mask);
    bit p0 = (rtr == 0) && (dlc >= 1);
    bit p1 = (rtr == 0) && (dlc >= 2);
    bit ok_a = 1, ok_b = 1, ok = 1;
    if (single) begin
      for (int i = 0; i < 32; i++) begin
        bit rx = 0, used = 0;
        if (ext) begin
          if (i >= 3) begin rx = id[i-3]; used = 1; end
          else if (i == 2) begin rx = rtr; used = 1; end
        end else begin
          if (i >= 21) begin rx = id[i-21]; used = 1; end
          else if (i == 20) begin rx = rtr; used = 1; end
          else if (i >= 8 && i < 16) begin rx = d0[i-8]; used = p0; end
          else if (i < 8) begin rx = d1[i]; used = p1; end
        end
        if (used && !mask[i] && rx != code[i]) ok = 0;
      end
      return ok;
    end
    for (int j = 0; j < 16; j++) begin
      bit rx = 0, used = 1;
      if (ext) rx = id[13+j];
      else if (j >= 5) rx = id[j-5];
      else if (j == 4) rx = rtr;
      else used = 0;
      if (used && !mask[16+j] && rx != code[16+j]) ok_a = 0;
      if (used && !mask[j] && rx != code[j]) ok_b = 0;
    end
    return ok_a || ok_b;
  endfunction

  task automatic send(input bit ext, input bit [28:0] id, input bit rtr, input bit [3:0] dlc,
                      input bit [7:0] d0, input bit [7:0] d1, input bit single,
                      input bit [31:0] code, input bit [31:0] mask,
                      input string req, input string what);
    bit exp;
    exp = ref_accept(ext, id, rtr, dlc, d0, d1, single, code, mask);
    @(negedge clk);
    ext_frame_i = ext; id_i = id; rtr_i = rtr; dlc_i = dlc; data0_i = d0; data1_i = d1;
    single_mode_i = single; acc_code_i = code; acc_mask_i = mask; frame_valid_i = 1'b1;
    @(negedge clk);
    frame_valid_i = 1'b0;
    id_i = ~id; acc_code_i = ~code;   // later changes must not matter (R7 sampling)
    check(accept_o, exp, req, what);
    @(negedge clk);
    check(accept_o, 1'b0, "R7", {what, " pulse ends"});
  endtask

  function automatic bit [31:0] std_word(bit [10:0] id, bit rtr, bit [7:0] d0, bit [7:0] d1);
    return {id, rtr, 4'b0000, d0, d1};
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit [31:0] w;
    // R1: reset
    repeat (3) @(negedge clk);
    check(accept_o, 1'b0, "R1", "during reset");
    frame_valid_i = 1'b1; acc_mask_i = '1;
    @(negedge clk);
    rst_n = 1'b1; frame_valid_i = 1'b0;
    check(accept_o, 1'b0, "R1", "first cycle after reset");
    acc_mask_i = '0;

    // R2: open mask
    send(0, 29'h5A5, 0, 8, 8'h11, 8'h22, 1, 32'h0, '1, "R2", "all don't care");
    // R3: exact standard match, and flips
    w = std_word(11'h3C5, 0, 8'hA7, 8'h5E);
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w, 32'h0, "R3", "std exact");
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w ^ 32'h0020_0000, 32'h0, "R3", "std id flip");
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w ^ 32'h0000_0100, 32'h0, "R3", "std d0 flip");
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w ^ 32'h0000_0080, 32'h0, "R3", "std d1 flip");
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w ^ 32'h000F_0000, 32'h0, "R3", "std gap flip");
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w ^ 32'h0010_0000, 32'h0, "R3", "std rtr flip");
    send(0, 29'h3C5, 0, 8, 8'hA7, 8'h5E, 1, w ^ 32'h0020_0000, 32'h0020_0000, "R2", "masked flip");
    // R4: absent bytes
    w = std_word(11'h123, 1, 8'h00, 8'h00);
    send(0, 29'h123, 1, 8, 8'hFF, 8'hFF, 1, w ^ 32'h0000_FFFF, 32'h0, "R4", "rtr skips data");
    w = std_word(11'h123, 0, 8'h00, 8'h00);
    send(0, 29'h123, 0, 0, 8'hFF, 8'hFF, 1, w ^ 32'h0000_FFFF, 32'h0, "R4", "dlc0 skips data");
    send(0, 29'h123, 0, 1, 8'h00, 8'hFF, 1, w ^ 32'h0000_00FF, 32'h0, "R4", "dlc1 skips byte1");
    send(0, 29'h123, 0, 1, 8'hFF, 8'h00, 1, w, 32'h0, "R4", "dlc1 compares byte0");
    send(0, 29'h123, 0, 12, 8'h00, 8'h01, 1, w, 32'h0, "R4", "dlc12 compares byte1");
    // R5: extended
    w = {29'h1ABC_DEF1, 1'b1, 2'b00};
    send(1, 29'h1ABC_DEF1, 1, 0, 0, 0, 1, w, 32'h0, "R5", "ext exact");
    send(1, 29'h1ABC_DEF1, 1, 0, 0, 0, 1, w ^ 32'h3, 32'h0, "R5", "ext low bits ignored");
    send(1, 29'h1ABC_DEF1, 1, 0, 0, 0, 1, w ^ 32'h4, 32'h0, "R5", "ext rtr flip");
    send(1, 29'h1ABC_DEF1, 1, 0, 0, 0, 1, w ^ 32'h8000_0000, 32'h0, "R5", "ext id28 flip");
    // R6 / R8: dual
    send(0, 29'h2F1, 0, 2, 8'h12, 8'h34, 0, {11'h2F1, 1'b0, 4'hF, 16'h0000}, 32'h0, "R6", "dual A only");
    send(0, 29'h2F1, 0, 2, 8'h12, 8'h34, 0, {16'h0000, 11'h2F1, 1'b0, 4'hA}, 32'h0, "R6", "dual B only");
    send(0, 29'h2F1, 0, 2, 8'h12, 8'h34, 0, {16'h0001, 16'h0020}, 32'h0, "R6", "dual neither");
    send(1, 29'h1234_5678, 0, 0, 0, 0, 0, {16'h0000, 29'h1234_5678 >> 13}, 32'h0, "R6", "dual ext B");
    send(0, 29'h2F1, 0, 2, 8'h12, 8'h34, 1, {11'h2F1, 1'b0, 4'hF, 16'h0000}, 32'h0, "R8", "single same code");

    // random mix
    void'($urandom(32'd2024));
    for (int k = 0; k < 1500; k++) begin
      bit ext = $urandom_range(0, 1);
      bit [28:0] id = 29'($urandom);
      bit rtr = ($urandom_range(0, 3) == 0);
      bit [3:0] dlc = 4'($urandom);
      bit [7:0] d0 = 8'($urandom), d1 = 8'($urandom);
      bit single = $urandom_range(0, 1);
      bit [31:0] code, mask, flips;
      code = ext ? {id, rtr, 2'b00} : std_word(id[10:0], rtr, d0, d1);
      if (!single && $urandom_range(0, 1)) code[15:0] = code[31:16];
      flips = 32'(1) << $urandom_range(0, 31);
      if ($urandom_range(0, 1)) code ^= flips;
      mask = $urandom & $urandom & $urandom;
      send(ext, id, rtr, dlc, d0, d1, single, code, mask, single ? "R2" : "R6", "random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule